// File: doc/BRIEF.md
# Pipelined Flash Program and Erase Sequencer

This block takes word-program and page-erase requests and runs them against a flash array one at a time. It has a one-deep holding slot, so software can load a second request while the first is still running. It only needs to look at the full flag before loading another. A program can only clear bits, and an erase sets a whole page to ones. Erasing the information block also wipes the whole data main block. For self-checking, the array is a small behavioural model with fixed program and erase durations set by parameters.

Reads of the two main memories go through a word read port. A read of program memory stalls while any operation aimed at program memory is running or waiting. A read of data memory stalls while anything is running or waiting. The information block is read through an address register that takes a byte address and a data output. Only even, word-aligned addresses are legal. Write permission comes in as a grant input sampled with each request.

Top module: `flash_seq`

## Requirements
- R1: A page erase (req_erase_i=1) to region 0 (program) or region 1 (data) sets every word of the page holding req_addr_i to all ones. A page is PAGE_WORDS consecutive words, and the page index is req_addr_i divided by PAGE_WORDS. Other pages keep their contents.
- R2: A program (req_erase_i=0) leaves the addressed word equal to its previous value ANDed with req_data_i.
- R3: A request accepted while the block is idle keeps busy_o high for exactly PROG_CYCLES cycles (program) or ERASE_CYCLES cycles (erase). The cycles start with the one after the accepting edge, and the array change is readable once busy_o has fallen.
- R4: busy_o is high while an operation runs or one is waiting, and full_o is high only while one is waiting. A request accepted during a running operation waits and starts on the cycle after that operation ends, so busy_o stays high for the sum of both durations.
- R5: A request presented while full_o is high is dropped: it has no effect on the array, and it sets overrun_o, which stays high until reset.
- R6: A request with grant_i low is ignored: busy_o stays low and the array is unchanged.
- R7: With rd_req_i high and rd_sel_i=0 (program memory), rd_stall_o is high exactly when an operation on region 0 is running or waiting. When rd_stall_o is high, rd_data_o is zero. Otherwise rd_data_o is the addressed word.
- R8: With rd_req_i high and rd_sel_i=1 (data memory), rd_stall_o is high whenever busy_o is high.
- R9: Region 2 or 3 is the information block. Erasing it sets every information word and every data-memory word to all ones, and leaves program memory unchanged. A program to it uses the low bits of req_addr_i as the word index.
- R10: ib_addr_i is a byte address loaded by ib_addr_we_i. When bit 0 of the loaded address is 0, from the cycle after loading, ib_data_o is the information word at the address shifted right by one. When bit 0 is 1, ib_data_o is all ones and align_err_o is high.
- R11: After reset, busy_o, full_o and overrun_o are low and every array word reads all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe, one cycle per request |
| req_erase_i | input | 1 | 1 selects page erase, 0 selects word program |
| req_region_i | input | 2 | 0 program memory, 1 data memory, 2 or 3 information block |
| req_addr_i | input | OFF_W | Word address within the region |
| req_data_i | input | DATA_W | Program data |
| grant_i | input | 1 | Write permission for the presented request |
| busy_o | output | 1 | Operation running or waiting |
| full_o | output | 1 | Holding slot occupied |
| overrun_o | output | 1 | Sticky: a request was dropped |
| rd_req_i | input | 1 | Main read request |
| rd_sel_i | input | 1 | 0 program memory, 1 data memory |
| rd_addr_i | input | OFF_W | Read word address |
| rd_data_o | output | DATA_W | Read word, zero when stalled or idle |
| rd_stall_o | output | 1 | Read held off by busy memory |
| ib_addr_we_i | input | 1 | Load the information address register |
| ib_addr_i | input | IB_W+1 | Information byte address |
| ib_data_o | output | DATA_W | Information word |
| align_err_o | output | 1 | Loaded information address is odd |

## Verification
The bench sweeps every word of both main memories with a distinct program pattern. It then programs the same words again with a second pattern, so that the result has to be the AND of the two and not just the last value written. Erases of single pages and of the information block check which words become all ones and which keep their data. Back-to-back and third requests show the difference between waiting, running and dropped requests. Reads during a program-memory operation and during a data-memory operation show that the two stall rules are separate.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [1:0] {
    RG_PROG = 2'd0,
    RG_DATA = 2'd1,
    RG_INFO = 2'd2,
    RG_INFO_ALT = 2'd3
  } region_e;
endpackage

// File: rtl/flash_req_queue.sv
module flash_req_queue
  import flash_seq_pkg::*;
#(
  parameter int OFF_W = 4,
  parameter int DATA_W = 16,
  parameter int PROG_CYCLES = 3,
  parameter int ERASE_CYCLES = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_erase_i,
  input  logic [1:0]        req_region_i,
  input  logic [OFF_W-1:0]  req_addr_i,
  input  logic [DATA_W-1:0] req_data_i,
  input  logic              grant_i,
  output logic              op_done_o,
  output logic              op_erase_o,
  output logic [1:0]        op_region_o,
  output logic [OFF_W-1:0]  op_addr_o,
  output logic [DATA_W-1:0] op_data_o,
  output logic              busy_o,
  output logic              full_o,
  output logic              overrun_o,
  output logic              prog_busy_o,
  output logic              data_busy_o
);
  localparam int MAX_CYC = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
  localparam int CNT_W = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] PROG_LAST = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] ERASE_LAST = CNT_W'(ERASE_CYCLES - 1);

  logic              act_valid_q, act_erase_q;
  logic [1:0]        act_region_q;
  logic [OFF_W-1:0]  act_addr_q;
  logic [DATA_W-1:0] act_data_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              pend_valid_q, pend_erase_q;
  logic [1:0]        pend_region_q;
  logic [OFF_W-1:0]  pend_addr_q;
  logic [DATA_W-1:0] pend_data_q;
  logic              overrun_q;

  logic req_live, acc, drop, done, act_free;

  assign req_live = req_valid_i & grant_i;
  assign acc      = req_live & ~pend_valid_q;
  assign drop     = req_live & pend_valid_q;
  assign done     = act_valid_q && (cnt_q == (act_erase_q ? ERASE_LAST : PROG_LAST));
  assign act_free = ~act_valid_q | done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_valid_q   <= 1'b0;
      act_erase_q   <= 1'b0;
      act_region_q  <= '0;
      act_addr_q    <= '0;
      act_data_q    <= '0;
      cnt_q         <= '0;
      pend_valid_q  <= 1'b0;
      pend_erase_q  <= 1'b0;
      pend_region_q <= '0;
      pend_addr_q   <= '0;
      pend_data_q   <= '0;
      overrun_q     <= 1'b0;
    end else begin
      overrun_q <= overrun_q | drop;
      if (act_free) begin
        cnt_q <= '0;
        if (pend_valid_q) begin
          act_valid_q  <= 1'b1;
          act_erase_q  <= pend_erase_q;
          act_region_q <= pend_region_q;
          act_addr_q   <= pend_addr_q;
          act_data_q   <= pend_data_q;
          pend_valid_q <= 1'b0;
        end else if (acc) begin
          act_valid_q  <= 1'b1;
          act_erase_q  <= req_erase_i;
          act_region_q <= req_region_i;
          act_addr_q   <= req_addr_i;
          act_data_q   <= req_data_i;
        end else begin
          act_valid_q <= 1'b0;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
        if (acc) begin
          pend_valid_q  <= 1'b1;
          pend_erase_q  <= req_erase_i;
          pend_region_q <= req_region_i;
          pend_addr_q   <= req_addr_i;
          pend_data_q   <= req_data_i;
        end
      end
    end
  end

  assign op_done_o   = done;
  assign op_erase_o  = act_erase_q;
  assign op_region_o = act_region_q;
  assign op_addr_o   = act_addr_q;
  assign op_data_o   = act_data_q;
  assign busy_o      = act_valid_q | pend_valid_q;
  assign full_o      = pend_valid_q;
  assign overrun_o   = overrun_q;
  assign prog_busy_o = (act_valid_q && region_e'(act_region_q) == RG_PROG) ||
                       (pend_valid_q && region_e'(pend_region_q) == RG_PROG);
  assign data_busy_o = (act_valid_q && region_e'(act_region_q) != RG_PROG) ||
                       (pend_valid_q && region_e'(pend_region_q) != RG_PROG);

  AST_DROP_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && grant_i && full_o |=> overrun_o); // R5
  AST_IDLE_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !(req_valid_i && grant_i) |=> !busy_o); // R6
  AST_WAIT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_valid_q && act_valid_q && !done |=> pend_valid_q && $stable(pend_addr_q)); // R4
endmodule

// File: rtl/flash_array.sv
module flash_array
  import flash_seq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PAGE_WORDS = 4,
  parameter int PAGES = 4,
  parameter int INFO_WORDS = 4,
  localparam int MAIN_WORDS = PAGE_WORDS * PAGES,
  localparam int OFF_W = $clog2(MAIN_WORDS),
  localparam int IB_W = $clog2(INFO_WORDS),
  localparam int PG_W = $clog2(PAGE_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_erase_i,
  input  logic [1:0]        wr_region_i,
  input  logic [OFF_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [OFF_W-1:0]  rd_addr_i,
  input  logic [IB_W-1:0]   ib_idx_i,
  output logic [DATA_W-1:0] prog_rd_o,
  output logic [DATA_W-1:0] data_rd_o,
  output logic [DATA_W-1:0] info_rd_o
);
  logic [DATA_W-1:0] prog_mem [MAIN_WORDS];
  logic [DATA_W-1:0] data_mem [MAIN_WORDS];
  logic [DATA_W-1:0] info_mem [INFO_WORDS];
  logic [PAGES-1:0]  page_hit;
  logic [IB_W-1:0]   wr_ib_idx;

  for (genvar p = 0; p < PAGES; p++) begin : g_page
    assign page_hit[p] = (wr_addr_i[OFF_W-1:PG_W] == (OFF_W-PG_W)'(p));
  end

  assign wr_ib_idx = wr_addr_i[IB_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < MAIN_WORDS; i++) begin
        prog_mem[i] <= '1;
        data_mem[i] <= '1;
      end
      for (int i = 0; i < INFO_WORDS; i++) info_mem[i] <= '1;
    end else if (wr_en_i) begin
      unique case (region_e'(wr_region_i))
        RG_PROG: begin
          if (wr_erase_i) begin
            for (int i = 0; i < MAIN_WORDS; i++)
              if (page_hit[i / PAGE_WORDS]) prog_mem[i] <= '1;
          end else begin
            prog_mem[wr_addr_i] <= prog_mem[wr_addr_i] & wr_data_i;
          end
        end
        RG_DATA: begin
          if (wr_erase_i) begin
            for (int i = 0; i < MAIN_WORDS; i++)
              if (page_hit[i / PAGE_WORDS]) data_mem[i] <= '1;
          end else begin
            data_mem[wr_addr_i] <= data_mem[wr_addr_i] & wr_data_i;
          end
        end
        default: begin
          if (wr_erase_i) begin
            for (int i = 0; i < INFO_WORDS; i++) info_mem[i] <= '1;
            for (int i = 0; i < MAIN_WORDS; i++) data_mem[i] <= '1;
          end else begin
            info_mem[wr_ib_idx] <= info_mem[wr_ib_idx] & wr_data_i;
          end
        end
      endcase
    end
  end

  assign prog_rd_o = prog_mem[rd_addr_i];
  assign data_rd_o = data_mem[rd_addr_i];
  assign info_rd_o = info_mem[ib_idx_i];

  AST_PROG_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !wr_erase_i && region_e'(wr_region_i) == RG_PROG && rd_addr_i == wr_addr_i
    |=> $stable(rd_addr_i) |-> (prog_rd_o & ~$past(prog_rd_o)) == '0); // R2
endmodule

// File: rtl/flash_ib_reader.sv
module flash_ib_reader #(
  parameter int DATA_W = 16,
  parameter int IB_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ib_addr_we_i,
  input  logic [IB_W:0]     ib_addr_i,
  input  logic [DATA_W-1:0] ib_word_i,
  output logic [IB_W-1:0]   ib_idx_o,
  output logic [DATA_W-1:0] ib_data_o,
  output logic              align_err_o
);
  logic [IB_W:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else if (ib_addr_we_i) addr_q <= ib_addr_i;
  end

  assign ib_idx_o    = addr_q[IB_W:1];
  assign align_err_o = addr_q[0];
  assign ib_data_o   = addr_q[0] ? '1 : ib_word_i;

  AST_IB_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ib_addr_we_i |=> $stable(align_err_o) && $stable(ib_idx_o)); // R10
endmodule

// File: rtl/flash_seq.sv
module flash_seq #(
  parameter int DATA_W = 16,
  parameter int PAGE_WORDS = 4,
  parameter int PAGES = 4,
  parameter int INFO_WORDS = 4,
  parameter int PROG_CYCLES = 3,
  parameter int ERASE_CYCLES = 6,
  localparam int OFF_W = $clog2(PAGE_WORDS * PAGES),
  localparam int IB_W = $clog2(INFO_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_erase_i,
  input  logic [1:0]        req_region_i,
  input  logic [OFF_W-1:0]  req_addr_i,
  input  logic [DATA_W-1:0] req_data_i,
  input  logic              grant_i,
  output logic              busy_o,
  output logic              full_o,
  output logic              overrun_o,
  input  logic              rd_req_i,
  input  logic              rd_sel_i,
  input  logic [OFF_W-1:0]  rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_stall_o,
  input  logic              ib_addr_we_i,
  input  logic [IB_W:0]     ib_addr_i,
  output logic [DATA_W-1:0] ib_data_o,
  output logic              align_err_o
);
  logic              op_done, op_erase;
  logic [1:0]        op_region;
  logic [OFF_W-1:0]  op_addr;
  logic [DATA_W-1:0] op_data;
  logic              prog_busy, data_busy;
  logic [DATA_W-1:0] prog_rd, data_rd, info_rd;
  logic [IB_W-1:0]   ib_idx;

  flash_req_queue #(
    .OFF_W(OFF_W), .DATA_W(DATA_W),
    .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
  ) u_queue (
    .clk_i, .rst_ni, .req_valid_i, .req_erase_i, .req_region_i, .req_addr_i,
    .req_data_i, .grant_i,
    .op_done_o(op_done), .op_erase_o(op_erase), .op_region_o(op_region),
    .op_addr_o(op_addr), .op_data_o(op_data),
    .busy_o, .full_o, .overrun_o,
    .prog_busy_o(prog_busy), .data_busy_o(data_busy)
  );

  flash_array #(
    .DATA_W(DATA_W), .PAGE_WORDS(PAGE_WORDS), .PAGES(PAGES), .INFO_WORDS(INFO_WORDS)
  ) u_array (
    .clk_i, .rst_ni,
    .wr_en_i(op_done), .wr_erase_i(op_erase), .wr_region_i(op_region),
    .wr_addr_i(op_addr), .wr_data_i(op_data),
    .rd_addr_i, .ib_idx_i(ib_idx),
    .prog_rd_o(prog_rd), .data_rd_o(data_rd), .info_rd_o(info_rd)
  );

  flash_ib_reader #(.DATA_W(DATA_W), .IB_W(IB_W)) u_ib (
    .clk_i, .rst_ni, .ib_addr_we_i, .ib_addr_i,
    .ib_word_i(info_rd), .ib_idx_o(ib_idx), .ib_data_o, .align_err_o
  );

  assign rd_stall_o = rd_req_i & (prog_busy | (rd_sel_i & data_busy));
  assign rd_data_o  = (rd_req_i & ~rd_stall_o) ? (rd_sel_i ? data_rd : prog_rd) : '0;

  AST_FULL_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> busy_o); // R4
  AST_DATA_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_i && rd_sel_i && busy_o |-> rd_stall_o); // R8
  AST_STALL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stall_o |-> rd_data_o == '0); // R7
  AST_MISALIGN_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_err_o |-> ib_data_o == '1); // R10
endmodule

// File: tb/flash_seq_bench.sv
module flash_seq_bench;
  localparam int DW = 16, PW = 4, NP = 4, IW = 4, PC = 3, EC = 6;
  localparam int MW = PW * NP;
  localparam int OW = $clog2(MW);
  localparam int IBW = $clog2(IW);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_erase = 0, grant = 1;
  logic [1:0] req_region = '0;
  logic [OW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic busy, full, overrun;
  logic rd_req = 0, rd_sel = 0;
  logic [OW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic rd_stall;
  logic ib_we = 0;
  logic [IBW:0] ib_addr = '0;
  logic [DW-1:0] ib_data;
  logic align_err;

  int n_chk = 0, n_err = 0;
  logic [DW-1:0] m_prog [MW];
  logic [DW-1:0] m_data [MW];
  logic [DW-1:0] m_info [IW];

  always #4 clk = ~clk;

  flash_seq #(.DATA_W(DW), .PAGE_WORDS(PW), .PAGES(NP), .INFO_WORDS(IW),
              .PROG_CYCLES(PC), .ERASE_CYCLES(EC)) u_flash_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_erase_i(req_erase),
    .req_region_i(req_region), .req_addr_i(req_addr), .req_data_i(req_data),
    .grant_i(grant), .busy_o(busy), .full_o(full), .overrun_o(overrun),
    .rd_req_i(rd_req), .rd_sel_i(rd_sel), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .rd_stall_o(rd_stall), .ib_addr_we_i(ib_we), .ib_addr_i(ib_addr),
    .ib_data_o(ib_data), .align_err_o(align_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model(input bit er, input logic [1:0] rg, input int a, input logic [DW-1:0] d);
    if (rg == 2'd0) begin
      if (er) begin for (int i = 0; i < MW; i++) if (i / PW == a / PW) m_prog[i] = '1; end
      else m_prog[a] = m_prog[a] & d;
    end else if (rg == 2'd1) begin
      if (er) begin for (int i = 0; i < MW; i++) if (i / PW == a / PW) m_data[i] = '1; end
      else m_data[a] = m_data[a] & d;
    end else begin
      if (er) begin
        for (int i = 0; i < IW; i++) m_info[i] = '1;
        for (int i = 0; i < MW; i++) m_data[i] = '1;
      end else m_info[a % IW] = m_info[a % IW] & d;
    end
  endfunction

  task automatic drive(input bit er, input logic [1:0] rg, input int a, input logic [DW-1:0] d);
    req_valid = 1; req_erase = er; req_region = rg; req_addr = OW'(a); req_data = d;
  endtask

  task automatic op(input bit er, input logic [1:0] rg, input int a, input logic [DW-1:0] d, input string tag);
    int len;
    @(negedge clk); drive(er, rg, a, d);
    @(negedge clk); req_valid = 0;
    len = 0;
    while (busy) begin len++; @(negedge clk); end
    chk(len == (er ? EC : PC), tag, len, er ? EC : PC);
    model(er, rg, a, d);
  endtask

  task automatic read_all(input string tag);
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < MW; i++) begin
        @(negedge clk); rd_req = 1; rd_sel = s[0]; rd_addr = OW'(i); #1;
        chk(!rd_stall && rd_data == (s == 0 ? m_prog[i] : m_data[i]), tag, rd_data,
            s == 0 ? m_prog[i] : m_data[i]);
      end
    @(negedge clk); rd_req = 0;
    for (int i = 0; i < IW; i++) begin
      @(negedge clk); ib_we = 1; ib_addr = (IBW+1)'(2 * i);
      @(negedge clk); ib_we = 0; #1;
      chk(ib_data == m_info[i] && !align_err, tag, ib_data, m_info[i]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int len;
    for (int i = 0; i < MW; i++) begin m_prog[i] = '1; m_data[i] = '1; end
    for (int i = 0; i < IW; i++) m_info[i] = '1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !full && !overrun, "R11 status", {busy, full, overrun}, 0);
    read_all("R11 erased");

    // R2 R3: two program passes, result is the AND
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < MW; i++) begin
        op(0, 2'd0, i, s == 0 ? DW'(16'hFFFF ^ (16'h1 << i)) : DW'(16'hF0F0 | i * 16'h0101), "R3 prog len");
        op(0, 2'd1, i, s == 0 ? DW'(16'h7FFF >> (i % 8)) : DW'(~(i * 16'h0111)), "R3 prog len");
      end
    read_all("R2 and-program");

    // R1: erase page 1 of program memory, page 2 of data memory
    op(1, 2'd0, PW + 1, '0, "R3 erase len");
    op(1, 2'd1, 2 * PW, '0, "R3 erase len");
    read_all("R1 page erase");

    // R4 R5: running + waiting + dropped
    @(negedge clk); drive(0, 2'd0, 3, 16'h00FF);
    @(negedge clk); drive(0, 2'd1, 5, 16'h0F0F);
    @(negedge clk); drive(0, 2'd0, 0, 16'h0000);
    chk(full && busy, "R4 full while waiting", {full, busy}, 2'b11);
    @(negedge clk); req_valid = 0;
    chk(overrun, "R5 overrun set", overrun, 1);
    len = 2;
    while (busy) begin len++; @(negedge clk); end
    chk(len == 2 * PC, "R4 back-to-back len", len, 2 * PC);
    chk(!full, "R4 full cleared", full, 0);
    model(0, 2'd0, 3, 16'h00FF);
    model(0, 2'd1, 5, 16'h0F0F);
    read_all("R5 dropped has no effect");
    chk(overrun, "R5 overrun sticky", overrun, 1);

    // R6: grant low
    @(negedge clk); grant = 0; drive(0, 2'd0, 2, 16'h0000);
    @(negedge clk); req_valid = 0; grant = 1;
    chk(!busy, "R6 busy stays low", busy, 0);
    @(negedge clk); rd_req = 1; rd_sel = 0; rd_addr = 2; #1;
    chk(rd_data == m_prog[2], "R6 array unchanged", rd_data, m_prog[2]);
    rd_req = 0;

    // R7 R8: stall during a program-memory erase
    @(negedge clk); drive(1, 2'd0, 0, '0);
    @(negedge clk); req_valid = 0; rd_req = 1; rd_sel = 0; rd_addr = 1; #1;
    chk(rd_stall && rd_data == '0, "R7 prog stall", {rd_stall, rd_data}, {1'b1, 16'h0});
    rd_sel = 1; #1;
    chk(rd_stall, "R8 data stall on prog op", rd_stall, 1);
    rd_req = 0;
    while (busy) @(negedge clk);
    model(1, 2'd0, 0, '0);
    // during a data-memory op
    @(negedge clk); drive(0, 2'd1, 7, 16'h1234);
    @(negedge clk); req_valid = 0; rd_req = 1; rd_sel = 0; rd_addr = 9; #1;
    chk(!rd_stall && rd_data == m_prog[9], "R7 prog readable", rd_data, m_prog[9]);
    rd_sel = 1; #1;
    chk(rd_stall && rd_data == '0, "R8 data stall", {rd_stall, rd_data}, {1'b1, 16'h0});
    rd_req = 0;
    while (busy) @(negedge clk);
    model(0, 2'd1, 7, 16'h1234);
    read_all("R7 after stalls");

    // R10: information block programming and reads
    for (int i = 0; i < IW; i++) op(0, 2'd2, i, DW'(16'hA5A5 ^ (i * 16'h1111)), "R3 info prog len");
    read_all("R10 aligned info");
    for (int i = 0; i < IW; i++) begin
      @(negedge clk); ib_we = 1; ib_addr = (IBW+1)'(2 * i + 1);
      @(negedge clk); ib_we = 0; #1;
      chk(ib_data == '1 && align_err, "R10 misaligned", {align_err, ib_data}, {1'b1, 16'hFFFF});
    end

    // R9: info erase wipes info and data memory
    op(1, 2'd3, 0, '0, "R3 info erase len");
    read_all("R9 info erase");

    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule